// File: doc/BRIEF.md
# Video Interrupt Controller

This block gathers four event sources from a display and sound subsystem and drives one active-low interrupt line to the host processor. The sources are the frame vertical sync pulse, a match between the live scanline counter and a programmable 9-bit target line, a sprite collision pulse with a 4-bit collision group, and a low fill level in the PCM sample buffer. The block does not detect collisions and does not hold any audio buffer. It only watches the signals that report those events.

The host reaches the block through a small byte-wide register port. One register holds the enable mask. A second register holds the status flags and the captured collision group. A third register is shared: a write sets the low byte of the target line, and a read returns the low byte of the live scanline. The ninth bit of each of these values sits in the enable register. The vsync, line and collision flags are cleared by writing 1 to them. The buffer-low flag follows the buffer level and ignores writes.

Top module: `vid_irq_ctrl`

## Requirements
- R1: After reset the enable mask, status flags, collision group and target line are all zero, and irqN is high.
- R2: A vsyncPulse sets status bit 0 and a collidePulse sets status bit 2 on the next clock edge, whatever the enable mask holds. If a set and a clear of the same flag arrive in the same cycle, the set wins.
- R3: A write to the status register (address 1) clears each of bits 0, 1 and 2 whose data bit is 1. A flag whose data bit is 0 stays as it was.
- R4: Status bit 3 is set on the clock edge after pcmFill falls below PCM_DEPTH/4, and clears on the edge after pcmFill reaches PCM_DEPTH/4 or more. A write to bit 3 has no effect.
- R5: Status bits 7:4 take the value of collideGroup on each collision pulse and keep it until the next pulse.
- R6: Status bit 1 is set on the clock edge where scanLine changes to a value equal to the 9-bit target line. It is not set again while scanLine holds that value.
- R7: A write to address 2 loads bits 7:0 of the target line, and bit 7 of a write to the enable register (address 0) loads target bit 8. Enable bit 7 always reads back as 0.
- R8: A read of address 2 returns scanLine[7:0], and enable-register bit 6 reads back as scanLine[8]. Writes to bits 6:4 of the enable register have no effect.
- R9: irqN is low, combinationally, exactly when some status bit n (n from 0 to 3) and enable bit n are both 1.
- R10: Address 0 is the enable register, with bit 0 for vsync, bit 1 for line match, bit 2 for collision and bit 3 for buffer low. Address 1 is status, and address 2 is the line register. Address 3 reads as zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr (combinational) |
| scanLine | input | 9 | Live scanline counter |
| vsyncPulse | input | 1 | One-cycle vertical sync event |
| collidePulse | input | 1 | One-cycle sprite collision event |
| collideGroup | input | 4 | Collision group, valid with collidePulse |
| pcmFill | input | FILL_W | Sample buffer fill level |
| irqN | output | 1 | Active-low interrupt request |

## Verification
The assertions assume a few things about the inputs. The vsync and collision inputs are single-cycle pulses that are sampled on the clock edge. collideGroup is valid in the cycle of its pulse. pcmFill and scanLine change only between clock edges and never reach X after reset. The bench drives every input on the falling clock edge, so each of these values is steady at the next rising edge. It drives the event inputs high for exactly one cycle. It moves pcmFill and scanLine in single steps that sit on either side of the quarter threshold and the target line.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam logic [1:0] ADDR_ENABLE = 2'd0;
  localparam logic [1:0] ADDR_STATUS = 2'd1;
  localparam logic [1:0] ADDR_LINE   = 2'd2;
  localparam logic [1:0] ADDR_SPARE  = 2'd3;

  typedef struct packed {
    logic       wrEnable;
    logic       wrLine;
    logic [2:0] clrFlags;
  } vicStrobes_t;
endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
(
  input  logic [1:0]  busAddr,
  input  logic        busWr,
  input  logic [2:0]  clrData,
  output vicStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    if (busWr) begin
      unique case (busAddr)
        ADDR_ENABLE: strobes.wrEnable = 1'b1;
        ADDR_STATUS: strobes.clrFlags = clrData;
        ADDR_LINE:   strobes.wrLine   = 1'b1;
        default:     strobes = '0;
      endcase
    end
  end
endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int PCM_DEPTH = 4096,
  parameter int FILL_W    = $clog2(PCM_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  vicStrobes_t       strobes,
  input  logic [7:0]        wrData,
  input  logic [1:0]        rdAddr,
  input  logic [8:0]        scanLine,
  input  logic              vsyncPulse,
  input  logic              collidePulse,
  input  logic [3:0]        collideGroup,
  input  logic [FILL_W-1:0] pcmFill,
  output logic [7:0]        rdData,
  output logic [7:0]        statusBits,
  output logic [3:0]        enBits,
  output logic              irqN
);
  localparam logic [FILL_W-1:0] QUARTER = FILL_W'(PCM_DEPTH / 4);

  logic [3:0] flags;
  logic [3:0] collData;
  logic [8:0] targetLine;
  logic [8:0] prevScan;
  logic       lineHit;
  logic       pcmLow;
  logic       unusedBits;

  assign unusedBits = ^wrData[6:4];
  assign lineHit    = (scanLine != prevScan) && (scanLine == targetLine);
  assign pcmLow     = (pcmFill < QUARTER);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags      <= '0;
      collData   <= '0;
      enBits     <= '0;
      targetLine <= '0;
      prevScan   <= '0;
    end else begin
      prevScan <= scanLine;
      if (strobes.wrEnable) begin
        enBits        <= wrData[3:0];
        targetLine[8] <= wrData[7];
      end
      if (strobes.wrLine) targetLine[7:0] <= wrData;
      flags[0] <= vsyncPulse   | (flags[0] & ~strobes.clrFlags[0]);
      flags[1] <= lineHit      | (flags[1] & ~strobes.clrFlags[1]);
      flags[2] <= collidePulse | (flags[2] & ~strobes.clrFlags[2]);
      flags[3] <= pcmLow;
      if (collidePulse) collData <= collideGroup;
    end
  end

  assign statusBits = {collData, flags};
  assign irqN       = ~|(flags & enBits);

  always_comb begin
    unique case (rdAddr)
      ADDR_ENABLE: rdData = {1'b0, scanLine[8], 2'b00, enBits};
      ADDR_STATUS: rdData = statusBits;
      ADDR_LINE:   rdData = scanLine[7:0];
      default:     rdData = 8'h00;
    endcase
  end
endmodule

// File: rtl/vid_irq_ctrl.sv
module vid_irq_ctrl
  import vic_pkg::*;
#(
  parameter int PCM_DEPTH = 4096,
  parameter int FILL_W    = $clog2(PCM_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWr,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic [8:0]        scanLine,
  input  logic              vsyncPulse,
  input  logic              collidePulse,
  input  logic [3:0]        collideGroup,
  input  logic [FILL_W-1:0] pcmFill,
  output logic              irqN
);
  vicStrobes_t strobes;
  logic [7:0]  statusBits;
  logic [3:0]  enBits;

  vic_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .clrData (busWrData[2:0]),
    .strobes (strobes)
  );

  vic_datapath #(.PCM_DEPTH(PCM_DEPTH), .FILL_W(FILL_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .wrData       (busWrData),
    .rdAddr       (busAddr),
    .scanLine     (scanLine),
    .vsyncPulse   (vsyncPulse),
    .collidePulse (collidePulse),
    .collideGroup (collideGroup),
    .pcmFill      (pcmFill),
    .rdData       (busRdData),
    .statusBits   (statusBits),
    .enBits       (enBits),
    .irqN         (irqN)
  );
endmodule

// File: rtl/vic_checker.sv
module vic_checker
  import vic_pkg::*;
#(
  parameter int PCM_DEPTH = 4096,
  parameter int FILL_W    = $clog2(PCM_DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        busAddr,
  input logic              busWr,
  input logic [7:0]        busWrData,
  input logic              vsyncPulse,
  input logic              collidePulse,
  input logic [3:0]        collideGroup,
  input logic [FILL_W-1:0] pcmFill,
  input logic [7:0]        statusBits,
  input logic [3:0]        enBits,
  input logic              irqN
);
  localparam int QUARTER = PCM_DEPTH / 4;

  assert_vsync_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    vsyncPulse |=> statusBits[0]);

  assert_w1c_vsync_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_STATUS && busWrData[0] && !vsyncPulse) |=> !statusBits[0]);

  assert_w0_keeps_R3: assert property (@(posedge clk) disable iff (!rstN)
    (statusBits[0] && busWr && busAddr == ADDR_STATUS && !busWrData[0]) |=> statusBits[0]);

  assert_pcm_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (int'(pcmFill) < QUARTER) |=> statusBits[3]);

  assert_pcm_ok_R4: assert property (@(posedge clk) disable iff (!rstN)
    (int'(pcmFill) >= QUARTER) |=> !statusBits[3]);

  assert_group_capture_R5: assert property (@(posedge clk) disable iff (!rstN)
    collidePulse |=> (statusBits[7:4] == $past(collideGroup)));

  assert_irq_active_R9: assert property (@(posedge clk) disable iff (!rstN)
    (statusBits[0] && enBits[0]) |-> !irqN);

  assert_irq_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (statusBits[3:0] == 4'h0) |-> irqN);
endmodule

bind vid_irq_ctrl vic_checker #(.PCM_DEPTH(PCM_DEPTH), .FILL_W(FILL_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .busAddr      (busAddr),
  .busWr        (busWr),
  .busWrData    (busWrData),
  .vsyncPulse   (vsyncPulse),
  .collidePulse (collidePulse),
  .collideGroup (collideGroup),
  .pcmFill      (pcmFill),
  .statusBits   (statusBits),
  .enBits       (enBits),
  .irqN         (irqN)
);

// File: tb/sim_vid_irq_ctrl.sv
module sim_vid_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PCM_DEPTH  = 4096;
  localparam int FILL_W     = $clog2(PCM_DEPTH + 1);
  localparam int QUARTER    = PCM_DEPTH / 4;

  logic              clk = 1'b0;
  logic              rstN;
  logic [1:0]        busAddr;
  logic              busWr;
  logic [7:0]        busWrData;
  logic [7:0]        busRdData;
  logic [8:0]        scanLine;
  logic              vsyncPulse;
  logic              collidePulse;
  logic [3:0]        collideGroup;
  logic [FILL_W-1:0] pcmFill;
  logic              irqN;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vid_irq_ctrl #(.PCM_DEPTH(PCM_DEPTH), .FILL_W(FILL_W)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .busRdData(busRdData), .scanLine(scanLine),
    .vsyncPulse(vsyncPulse), .collidePulse(collidePulse),
    .collideGroup(collideGroup), .pcmFill(pcmFill), .irqN(irqN)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWr = 1'b1; busWrData = d;
    tick();
    busWr = 1'b0; busWrData = 8'h00;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic pulseVsync();
    vsyncPulse = 1'b1; tick(); vsyncPulse = 1'b0;
  endtask

  task automatic pulseCollide(input logic [3:0] g);
    collidePulse = 1'b1; collideGroup = g; tick();
    collidePulse = 1'b0; collideGroup = 4'h0;
  endtask

  task automatic testReset();
    logic [7:0] d;
    regRead(2'd0, d); check("R1 enable", int'(d & 8'h8F), 0);
    regRead(2'd1, d); check("R1 status", int'(d), 0);
    check("R1 irqN", int'(irqN), 1);
  endtask

  task automatic testVsyncAndClear();
    logic [7:0] d;
    pulseVsync();
    regRead(2'd1, d); check("R2 vsync sets bit0 with mask off", int'(d[0]), 1);
    check("R9 masked flag leaves irqN high", int'(irqN), 1);
    regWrite(2'd1, 8'h00);
    regRead(2'd1, d); check("R3 write 0 keeps bit0", int'(d[0]), 1);
    regWrite(2'd1, 8'h01);
    regRead(2'd1, d); check("R3 write 1 clears bit0", int'(d[0]), 0);
    // Set and clear in the same cycle: set wins
    busAddr = 2'd1; busWr = 1'b1; busWrData = 8'h01; vsyncPulse = 1'b1;
    tick();
    busWr = 1'b0; vsyncPulse = 1'b0;
    regRead(2'd1, d); check("R2 set beats clear", int'(d[0]), 1);
    regWrite(2'd1, 8'h01);
  endtask

  task automatic testCollide();
    logic [7:0] d;
    pulseCollide(4'hA);
    regRead(2'd1, d); check("R2 collide sets bit2", int'(d[2]), 1);
    check("R5 group captured", int'(d[7:4]), 'hA);
    regWrite(2'd1, 8'h04);
    tick();
    regRead(2'd1, d); check("R3 clear bit2", int'(d[2]), 0);
    check("R5 group held", int'(d[7:4]), 'hA);
    pulseCollide(4'h5);
    regRead(2'd1, d); check("R5 group replaced", int'(d[7:4]), 5);
    regWrite(2'd1, 8'h04);
  endtask

  task automatic testPcm();
    logic [7:0] d;
    pcmFill = FILL_W'(QUARTER - 1); tick();
    regRead(2'd1, d); check("R4 low below quarter", int'(d[3]), 1);
    regWrite(2'd1, 8'h08);
    regRead(2'd1, d); check("R4 write ignored", int'(d[3]), 1);
    pcmFill = FILL_W'(QUARTER); tick();
    regRead(2'd1, d); check("R4 clears at quarter", int'(d[3]), 0);
  endtask

  task automatic testLine();
    logic [7:0] d;
    regWrite(2'd0, 8'h80);            // R7: target bit 8 via enable bit 7
    regWrite(2'd2, 8'h05);            // R7: target low byte
    regRead(2'd0, d); check("R7 enable bit7 reads 0", int'(d[7]), 0);
    scanLine = 9'h005; tick();
    regRead(2'd1, d); check("R6 bit8 mismatch no hit", int'(d[1]), 0);
    scanLine = 9'h104; tick();
    scanLine = 9'h105; tick();
    regRead(2'd1, d); check("R6 hit on change to target", int'(d[1]), 1);
    regWrite(2'd1, 8'h02);
    tick(); tick();
    regRead(2'd1, d); check("R6 no re-hit while steady", int'(d[1]), 0);
  endtask

  task automatic testReadback();
    logic [7:0] d;
    scanLine = 9'h1C3; tick();
    regRead(2'd2, d); check("R8 scanline low byte", int'(d), 'hC3);
    regWrite(2'd0, 8'h70);
    regRead(2'd0, d); check("R8 bit6 mirrors scanLine[8]", int'(d[6]), 1);
    check("R8 bits 5:4 unaffected", int'(d[5:4]), 0);
    scanLine = 9'h0C3; tick();
    regRead(2'd0, d); check("R8 bit6 follows scanLine", int'(d[6]), 0);
  endtask

  task automatic testIrqAndSpare();
    logic [7:0] d;
    regWrite(2'd0, 8'h01);
    regRead(2'd0, d); check("R10 enable bit0 stored", int'(d[3:0]), 1);
    pulseVsync();
    check("R9 irq asserted", int'(irqN), 0);
    regWrite(2'd0, 8'h08);
    check("R9 masked after enable change", int'(irqN), 1);
    pcmFill = FILL_W'(3); tick();
    check("R9 buffer-low drives irq", int'(irqN), 0);
    pcmFill = FILL_W'(2000); tick();
    regWrite(2'd3, 8'hFF);
    regRead(2'd3, d); check("R10 spare reads zero", int'(d), 0);
    regRead(2'd0, d); check("R10 spare write ignored", int'(d[3:0]), 8);
    regRead(2'd1, d); check("R10 status untouched by spare", int'(d[0]), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; busAddr = 2'd0; busWr = 1'b0; busWrData = 8'h00;
    scanLine = 9'h000; vsyncPulse = 1'b0; collidePulse = 1'b0;
    collideGroup = 4'h0; pcmFill = FILL_W'(2000);
    @(negedge clk); tick(); tick();
    testReset();
    rstN = 1'b1;
    tick();
    testVsyncAndClear();
    testCollide();
    testPcm();
    testLine();
    testReadback();
    testIrqAndSpare();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule